// File: doc/BRIEF.md
# LDPC Variable-Node Column Update

This block carries out the variable-node half of one iteration of a min-sum LDPC decoder for a single code column. Each cycle it can accept one column. A column is a signed channel LLR plus one check-to-variable message per check edge of that column. All messages are 6-bit two's complement. The block sums everything into a column total. For each edge it then returns the total minus that edge's own message. Each of these extrinsic results is clamped and re-encoded in sign-magnitude for the check-node side. The sign of the total is also provided as the hard decision for the code bit.

The column degree `DEG` is a parameter. Degrees 2, 3 and 6 are the intended cases, giving 3-, 4- and 7-operand sums. Shallow columns (degree 3 or less) use one register stage for the sum and one for the output, so their latency is 2 cycles. The degree-6 column has a deeper adder tree. It therefore adds a register between the pairwise partial sums and the final total, which gives a latency of 3 cycles. A valid flag travels in step with the data in every variant.

Top module: `vnp_column_update`

## Requirements
- R1: `hard_bit` is 1 when the sum of `llr_in` and all `DEG` edge messages is negative, and 0 when that sum is zero or positive.
- R2: The output word of edge i equals the column total minus the input message of edge i, after the clamping of R4.
- R3: The internal total is wide enough that every sum of `DEG+1` operands in the range -32..31 is exact, including all operands equal to -32.
- R4: Each extrinsic result is clamped to the range -31..+31 before encoding.
- R5: Output words are sign-magnitude. Bit 5 is the sign (1 = negative) and bits 4:0 are the magnitude. Zero is encoded as 000000, and 100000 never appears on a valid output.
- R6: `out_valid` follows `in_valid` by exactly 2 cycles for `DEG` of 3 or less, and by exactly 3 cycles for larger degrees. It stays low when no column was accepted that many cycles earlier.
- R7: A new column can be accepted every cycle, and back-to-back columns each produce their own correct result.
- R8: While `rst_n` is low, `out_valid` is 0. A column that is in flight when reset arrives never produces a valid output.
- R9: Edge i occupies bits [6i+5:6i] of both `c2v_in` and `v2c_out`. Input messages are two's complement and outputs are sign-magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A column is presented this cycle |
| llr_in | input | W | Channel LLR, two's complement |
| c2v_in | input | DEG*W | Check-to-variable messages, one W-bit field per edge |
| out_valid | output | 1 | Results for a column are present |
| v2c_out | output | DEG*W | Extrinsic messages, sign-magnitude, one field per edge |
| hard_bit | output | 1 | Hard decision, 1 for a negative total |

## Verification
The bench applies the same stimulus to a degree-6 and a degree-3 instance, so both the shallow and the deep pipeline are checked against the expected latency. A design with the wrong stage count would show results one cycle early or late and would fail the valid checks. The all -32 and all +31 columns exercise the extremes: a sum register that is too narrow would wrap and produce a result of the wrong sign, and a missing clamp would leave a magnitude above 31. Columns with a total of exactly zero or exactly -1 test the boundaries of the hard decision and of sign-magnitude encoding; a design that encodes negative zero, or that treats zero as negative, fails there. Distinct per-edge values, back-to-back streams, idle gaps and a reset in the middle of a stream show up any swapped edge fields, results that leak between columns, and in-flight columns that survive reset.

// File: rtl/vnp_pkg.sv
package vnp_pkg;

    typedef enum logic [0:0] {
        TREE_SHALLOW,
        TREE_DEEP
    } tree_kind_e;

    typedef enum logic [1:0] {
        CLAMP_NONE,
        CLAMP_HIGH,
        CLAMP_LOW
    } clamp_e;

    function automatic tree_kind_e tree_for_degree(input int deg);
        return (deg > 3) ? TREE_DEEP : TREE_SHALLOW;
    endfunction

    function automatic int latency_for_degree(input int deg);
        return (deg > 3) ? 3 : 2;
    endfunction

endpackage

// File: rtl/vnp_sum_tree.sv
module vnp_sum_tree
    import vnp_pkg::*;
#(
    parameter int DEG = 6,
    parameter int W   = 6,
    parameter int SW  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [W-1:0]         llr_in,
    input  logic [DEG*W-1:0]     c2v_in,
    output logic                 sum_valid,
    output logic signed [SW-1:0] total,
    output logic [DEG*W-1:0]     c2v_d
);
    localparam tree_kind_e KIND = tree_for_degree(DEG);
    localparam int NI    = DEG + 1;
    localparam int NPAIR = (NI + 1) / 2;

    logic signed [SW-1:0] opnd [NI];

    assign opnd[0] = SW'($signed(llr_in));
    for (genvar k = 0; k < DEG; k++) begin : g_ext
        assign opnd[k+1] = SW'($signed(c2v_in[k*W +: W]));
    end

    if (KIND == TREE_SHALLOW) begin : g_shallow
        logic signed [SW-1:0] acc;

        always_comb begin
            acc = '0;
            for (int k = 0; k < NI; k++) begin
                acc = acc + opnd[k];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_valid <= 1'b0;
            end else begin
                sum_valid <= in_valid;
            end
        end

        always_ff @(posedge clk) begin
            total <= acc;
            c2v_d <= c2v_in;
        end
    end else begin : g_deep
        logic signed [SW-1:0] pair_q [NPAIR];
        logic                 stage_valid;
        logic [DEG*W-1:0]     c2v_q;
        logic signed [SW-1:0] acc;

        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            if (2*p + 1 < NI) begin : g_two
                always_ff @(posedge clk) begin
                    pair_q[p] <= opnd[2*p] + opnd[2*p+1];
                end
            end else begin : g_one
                always_ff @(posedge clk) begin
                    pair_q[p] <= opnd[2*p];
                end
            end
        end

        always_comb begin
            acc = '0;
            for (int p = 0; p < NPAIR; p++) begin
                acc = acc + pair_q[p];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_valid <= 1'b0;
                sum_valid   <= 1'b0;
            end else begin
                stage_valid <= in_valid;
                sum_valid   <= stage_valid;
            end
        end

        always_ff @(posedge clk) begin
            c2v_q <= c2v_in;
            c2v_d <= c2v_q;
            total <= acc;
        end
    end

endmodule

// File: rtl/vnp_extrinsic.sv
module vnp_extrinsic
    import vnp_pkg::*;
#(
    parameter int DEG = 6,
    parameter int W   = 6,
    parameter int SW  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sum_valid,
    input  logic signed [SW-1:0] total,
    input  logic [DEG*W-1:0]     c2v_d,
    output logic                 out_valid,
    output logic [DEG*W-1:0]     v2c_out,
    output logic                 hard_bit
);
    localparam logic signed [SW-1:0] POS_LIM = SW'((2 ** (W-1)) - 1);
    localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        logic signed [SW-1:0] diff;
        logic signed [SW-1:0] clamped;
        logic signed [SW-1:0] mag;
        clamp_e               cls;
        logic [W-1:0]         word;

        assign diff = total - SW'($signed(c2v_d[e*W +: W]));

        always_comb begin
            if (diff > POS_LIM) begin
                cls = CLAMP_HIGH;
            end else if (diff < NEG_LIM) begin
                cls = CLAMP_LOW;
            end else begin
                cls = CLAMP_NONE;
            end
        end

        always_comb begin
            unique case (cls)
                CLAMP_HIGH: clamped = POS_LIM;
                CLAMP_LOW:  clamped = NEG_LIM;
                default:    clamped = diff;
            endcase
            mag  = clamped[SW-1] ? -clamped : clamped;
            word = {clamped[SW-1], mag[W-2:0]};
        end

        always_ff @(posedge clk) begin
            v2c_out[e*W +: W] <= word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= sum_valid;
        end
    end

    always_ff @(posedge clk) begin
        hard_bit <= total[SW-1];
    end

endmodule

// File: rtl/vnp_column_update.sv
module vnp_column_update #(
    parameter int DEG = 6,
    parameter int W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     llr_in,
    input  logic [DEG*W-1:0] c2v_in,
    output logic             out_valid,
    output logic [DEG*W-1:0] v2c_out,
    output logic             hard_bit
);
    localparam int SW = W + $clog2(DEG + 1) + 1;

    logic                 sum_valid;
    logic signed [SW-1:0] total;
    logic [DEG*W-1:0]     c2v_d;

    vnp_sum_tree #(.DEG(DEG), .W(W), .SW(SW)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .llr_in    (llr_in),
        .c2v_in    (c2v_in),
        .sum_valid (sum_valid),
        .total     (total),
        .c2v_d     (c2v_d)
    );

    vnp_extrinsic #(.DEG(DEG), .W(W), .SW(SW)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_valid (sum_valid),
        .total     (total),
        .c2v_d     (c2v_d),
        .out_valid (out_valid),
        .v2c_out   (v2c_out),
        .hard_bit  (hard_bit)
    );

endmodule

// File: rtl/vnp_column_update_chk.sv
module vnp_column_update_chk
    import vnp_pkg::*;
#(
    parameter int DEG = 6,
    parameter int W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     llr_in,
    input logic [DEG*W-1:0] c2v_in,
    input logic             out_valid,
    input logic [DEG*W-1:0] v2c_out,
    input logic             hard_bit
);
    localparam int LAT = latency_for_degree(DEG);
    localparam int CW  = $clog2(LAT + 1);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != CW'(LAT)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    a_r1_zero_column: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CW'(LAT) && $past(in_valid && llr_in == '0 && c2v_in == '0, LAT))
        |-> (v2c_out == '0 && !hard_bit));

    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

    for (genvar e = 0; e < DEG; e++) begin : g_edge_chk
        a_r5_no_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (v2c_out[e*W +: W] != {1'b1, {(W-1){1'b0}}}));
    end

endmodule

bind vnp_column_update vnp_column_update_chk #(.DEG(DEG), .W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .llr_in    (llr_in),
    .c2v_in    (c2v_in),
    .out_valid (out_valid),
    .v2c_out   (v2c_out),
    .hard_bit  (hard_bit)
);

// File: tb/vnp_column_update_tb.sv
module vnp_column_update_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  llr_in = '0;
    logic [35:0] c2v_big = '0;
    logic        ov_big, hb_big, ov_small, hb_small;
    logic [35:0] out_big;
    logic [17:0] out_small;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int v_llr [16];
    int v_c   [16][6];
    bit v_on  [16];

    always #5 clk = ~clk;

    vnp_column_update #(.DEG(6), .W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .llr_in(llr_in),
        .c2v_in(c2v_big), .out_valid(ov_big), .v2c_out(out_big), .hard_bit(hb_big)
    );

    vnp_column_update #(.DEG(3), .W(6)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .llr_in(llr_in),
        .c2v_in(c2v_big[17:0]), .out_valid(ov_small), .v2c_out(out_small), .hard_bit(hb_small)
    );

    function automatic logic [5:0] encode(input int v);
        int s;
        s = (v > 31) ? 31 : ((v < -31) ? -31 : v);
        return (s < 0) ? {1'b1, 5'(-s)} : {1'b0, 5'(s)};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_dut(input int deg, input int idx, input int n, input logic ov,
                             input logic [35:0] data, input logic hb, input string tag);
        int total;
        if (idx < 0 || idx >= n || !v_on[idx]) begin
            check($sformatf("R6 %s deg%0d idle valid", tag, deg), 36'(ov), 36'(0));
        end else begin
            check($sformatf("R6 %s deg%0d valid idx%0d", tag, deg, idx), 36'(ov), 36'(1));
            total = v_llr[idx];
            for (int k = 0; k < deg; k++) total += v_c[idx][k];
            check($sformatf("R1 %s deg%0d hard idx%0d", tag, deg, idx), 36'(hb), 36'(total < 0));
            for (int k = 0; k < deg; k++) begin
                check($sformatf("R2 R9 %s deg%0d edge%0d idx%0d", tag, deg, k, idx),
                      36'(data[k*6 +: 6]), 36'(encode(total - v_c[idx][k])));
            end
        end
    endtask

    task automatic run_stream(input int n, input string tag);
        for (int t = 0; t < n + 3; t++) begin
            @(negedge clk);
            check_dut(3, t - 2, n, ov_small, 36'(out_small), hb_small, tag);
            check_dut(6, t - 3, n, ov_big, out_big, hb_big, tag);
            if (t < n) begin
                in_valid = v_on[t];
                llr_in = 6'(v_llr[t]);
                for (int k = 0; k < 6; k++) c2v_big[k*6 +: 6] = 6'(v_c[t][k]);
            end else begin
                in_valid = 1'b0;
                llr_in = '0;
                c2v_big = '0;
            end
        end
    endtask

    task automatic set_vec(input int i, input int l, input int c0, input int c1, input int c2,
                           input int c3, input int c4, input int c5);
        v_on[i] = 1; v_llr[i] = l;
        v_c[i][0] = c0; v_c[i][1] = c1; v_c[i][2] = c2;
        v_c[i][3] = c3; v_c[i][4] = c4; v_c[i][5] = c5;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R8 reset deg6 valid", 36'(ov_big), 36'(0));
        check("R8 reset deg3 valid", 36'(ov_small), 36'(0));
        rst_n = 1'b1;
    endtask

    task automatic t_zero_column();
        set_vec(0, 0, 0, 0, 0, 0, 0, 0);
        run_stream(1, "R5 zero column");
    endtask

    task automatic t_distinct_edges();
        set_vec(0, 5, 1, -2, 3, -4, 5, -6);
        run_stream(1, "R2 R9 distinct edges");
    endtask

    task automatic t_extremes();
        set_vec(0, -32, -32, -32, -32, -32, -32, -32);
        set_vec(1, 31, 31, 31, 31, 31, 31, 31);
        run_stream(2, "R3 R4 extremes");
    endtask

    task automatic t_sign_boundary();
        set_vec(0, -1, 0, 0, 0, 0, 0, 0);
        set_vec(1, 3, -3, 0, 0, 2, -2, 0);
        set_vec(2, 0, 20, 20, -9, 0, 0, 0);
        run_stream(3, "R1 R5 sign boundary");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 10; i++) begin
            set_vec(i, ((i * 13) % 64) - 32, ((i * 7) % 64) - 32, ((i * 29 + 5) % 64) - 32,
                    ((i * 11 + 3) % 64) - 32, ((i * 17 + 40) % 64) - 32,
                    ((i * 5 + 20) % 64) - 32, ((i * 23 + 9) % 64) - 32);
        end
        run_stream(10, "R7 back to back");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 6; i++) begin
            set_vec(i, i - 3, 2 * i, -i, 4, -5, i, 1);
            v_on[i] = (i % 2 == 0);
        end
        run_stream(6, "R6 gaps");
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        in_valid = 1'b1; llr_in = 6'd9; c2v_big = '1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            check("R8 mid reset deg6 valid", 36'(ov_big), 36'(0));
            check("R8 mid reset deg3 valid", 36'(ov_small), 36'(0));
        end
        c2v_big = '0; llr_in = '0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) v_on[i] = 0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_zero_column();
        t_distinct_edges();
        t_extremes();
        t_sign_boundary();
        t_stream();
        t_gaps();
        t_mid_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule